// File: doc/BRIEF.md
# Sequential Power-Series Arctangent Unit

This block returns an approximate arctangent of one signed fixed-point argument in the range −1 to +1. It sums the odd power series x − x³/3 + x⁵/5 − x⁷/7, truncated after `NTERMS` terms (four by default). The series is evaluated over several clock cycles in a registered datapath built around one shared 32×32 multiplier. No division is used. Each 1/(2k+1) weight is a fixed-point reciprocal constant that is computed at elaboration time and applied through the same multiplier. Each higher odd power is formed by multiplying the previous power by a stored x².

Arguments and results are 32-bit signed words in Q2.30 format: two integer bits, including the sign, and thirty fraction bits, so 1.0 is `0x40000000`. Any argument beyond ±1.0 is clamped to ±1.0 before use.

The argument enters through a valid/ready handshake. The unit accepts one argument at a time and keeps `in_ready` low until its result has been taken. The result leaves through a second valid/ready handshake. While `out_ready` is low, `out_valid` and `out_angle` hold, and no new argument is accepted, so the back-pressure reaches the input side.

Top module: `series_atan`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `in_ready` is 1, `out_valid` is 0 and `out_angle` is 0.
- R2: An argument is taken at a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle `in_ready` stays 0 until the result has been handed over.
- R3: `in_valid` and `in_arg` are ignored while `in_ready` is 0, so the result depends only on the argument that was accepted.
- R4: `out_valid` rises exactly 1 + 2·(NTERMS−1) clock edges after the accepting edge, which is 7 edges for the default of four terms.
- R5: While `out_valid` is 1 and `out_ready` is 0, both `out_valid` and `out_angle` hold. The edge with `out_ready` at 1 ends the transfer, and `in_ready` is 1 in the following cycle.
- R6: The result is bit-exact with the following model. Set p = x, acc = x and x2 = rnd(x·x). For k = 1, 2, 3: set p = rnd(p·x2), then t = rnd(p·c_k), and subtract t from acc when k is odd or add it when k is even. Here rnd(v) = (v + 2^29) >>> 30 on the 64-bit product, keeping the low 32 bits, and c_k = round(2^30/(2k+1)), which gives 357913941, 214748365 and 153391689.
- R7: Read as Q2.30 radians, the result is within |x|^9/9 + 16 LSB of the true arctangent.
- R8: An argument above `0x40000000` (+1.0) is treated as +1.0, and one below `0xC0000000` (−1.0) is treated as −1.0.
- R9: `out_angle` changes only at the edge where `out_valid` rises. It keeps the last result while idle and while the next argument is being processed.
- R10: An argument of zero yields a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Argument offered |
| in_ready | output | 1 | Unit is idle and will take an argument |
| in_arg | input | 32 | Signed Q2.30 argument |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_angle | output | 32 | Signed Q2.30 angle in radians |

## Verification
The checks look for a wrong internal state at the ports and at a known time. A sequencing error, such as a skipped or repeated power step, moves the `out_valid` rise away from the seventh edge. It also changes the result by whole series terms, so a bit-exact comparison catches it on the first argument that is not zero. A wrong reciprocal constant, term sign or rounding offset shifts the result by at least one LSB, which the exact model exposes on the first ordinary argument. A broken handshake shows up within one cycle, either as `in_ready` returning too early or as `out_angle` moving while the consumer stalls.

// File: rtl/atan_series_pkg.sv
package atan_series_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned FRAC_W = 30;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SQUARE,
    ST_POWER,
    ST_TERM,
    ST_HOLD
  } seq_state_e;

  // Fixed-point reciprocal of an odd divisor, rounded to nearest.
  function automatic logic [63:0] recip_q(input int unsigned den, input int unsigned frac);
    logic [63:0] num;
    num = (64'd1 << frac) + 64'(den / 2);
    return num / 64'(den);
  endfunction

endpackage

// File: rtl/atan_prod_round.sv
module atan_prod_round
  import atan_series_pkg::*;
#(
  parameter int unsigned W    = DATA_W,
  parameter int unsigned FRAC = FRAC_W
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] prod_q
);

  localparam int unsigned PW = 2 * W;

  logic signed [PW-1:0] full_prod;
  logic signed [PW-1:0] biased;

  assign full_prod = $signed(op_a) * $signed(op_b);
  // Round half up, then truncate back to the working width.
  assign biased    = full_prod + (PW'(1) <<< (FRAC - 1));
  assign prod_q    = W'(biased >>> FRAC);

endmodule

// File: rtl/atan_seq_ctrl.sv
module atan_seq_ctrl
  import atan_series_pkg::*;
#(
  parameter int unsigned NTERMS = 4,
  parameter int unsigned IDX_W  = (NTERMS > 1) ? $clog2(NTERMS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid,
  output logic             accept,
  output logic             finish,
  output seq_state_e       state,
  output logic [IDX_W-1:0] term_idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NTERMS - 1);

  seq_state_e state_nx;
  logic [IDX_W-1:0] idx_nx;

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_HOLD);
  assign accept    = in_ready && in_valid;

  generate
    if (NTERMS > 1) begin : g_multi
      assign finish = (state == ST_TERM) && (term_idx == LAST_IDX);
    end else begin : g_single
      assign finish = (state == ST_SQUARE);
    end
  endgenerate

  always_comb begin
    state_nx = state;
    idx_nx   = term_idx;
    unique case (state)
      ST_IDLE:   if (in_valid) state_nx = ST_SQUARE;
      ST_SQUARE: begin
        idx_nx   = IDX_W'(1);
        state_nx = (NTERMS > 1) ? ST_POWER : ST_HOLD;
      end
      ST_POWER:  state_nx = ST_TERM;
      ST_TERM: begin
        if (term_idx == LAST_IDX) begin
          state_nx = ST_HOLD;
        end else begin
          idx_nx   = term_idx + IDX_W'(1);
          state_nx = ST_POWER;
        end
      end
      ST_HOLD:   if (out_ready) state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      term_idx <= '0;
    end else begin
      state    <= state_nx;
      term_idx <= idx_nx;
    end
  end

endmodule

// File: rtl/atan_datapath.sv
module atan_datapath
  import atan_series_pkg::*;
#(
  parameter int unsigned W      = DATA_W,
  parameter int unsigned FRAC   = FRAC_W,
  parameter int unsigned NTERMS = 4,
  parameter int unsigned IDX_W  = (NTERMS > 1) ? $clog2(NTERMS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             finish,
  input  seq_state_e       state,
  input  logic [IDX_W-1:0] term_idx,
  input  logic [W-1:0]     in_arg,
  output logic [W-1:0]     result
);

  localparam logic signed [W-1:0] POS_ONE = W'(1) <<< FRAC;
  localparam logic signed [W-1:0] NEG_ONE = -POS_ONE;

  logic [W-1:0] recip [NTERMS];

  generate
    for (genvar k = 0; k < NTERMS; k++) begin : g_recip
      assign recip[k] = W'(recip_q(2 * k + 1, FRAC));
    end
  endgenerate

  logic [W-1:0] x_q, x2_q, pow_q, acc_q;
  logic [W-1:0] mul_a, mul_b, mul_y;
  logic [W-1:0] arg_clamped, acc_nx;

  // Arguments outside [-1, +1] are pinned to the nearest limit.
  always_comb begin
    if ($signed(in_arg) > POS_ONE)      arg_clamped = POS_ONE;
    else if ($signed(in_arg) < NEG_ONE) arg_clamped = NEG_ONE;
    else                                arg_clamped = in_arg;
  end

  // One multiplier, operands picked by the sequence step.
  always_comb begin
    unique case (state)
      ST_SQUARE: begin mul_a = x_q;   mul_b = x_q;             end
      ST_POWER:  begin mul_a = pow_q; mul_b = x2_q;            end
      ST_TERM:   begin mul_a = pow_q; mul_b = recip[term_idx]; end
      default:   begin mul_a = '0;    mul_b = '0;              end
    endcase
  end

  atan_prod_round #(.W(W), .FRAC(FRAC)) u_mul (
    .op_a  (mul_a),
    .op_b  (mul_b),
    .prod_q(mul_y)
  );

  // Odd-numbered terms subtract, even-numbered terms add.
  assign acc_nx = term_idx[0] ? (acc_q - mul_y) : (acc_q + mul_y);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      x2_q   <= '0;
      pow_q  <= '0;
      acc_q  <= '0;
      result <= '0;
    end else begin
      if (accept) x_q <= arg_clamped;
      unique case (state)
        ST_SQUARE: begin
          x2_q  <= mul_y;
          pow_q <= x_q;
          acc_q <= x_q;
        end
        ST_POWER: pow_q <= mul_y;
        ST_TERM:  acc_q <= acc_nx;
        default: ;
      endcase
      if (finish) result <= (state == ST_SQUARE) ? x_q : acc_nx;
    end
  end

endmodule

// File: rtl/series_atan.sv
module series_atan
  import atan_series_pkg::*;
#(
  parameter int unsigned W      = DATA_W,
  parameter int unsigned FRAC   = FRAC_W,
  parameter int unsigned NTERMS = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_arg,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_angle
);

  localparam int unsigned IDX_W = (NTERMS > 1) ? $clog2(NTERMS) : 1;

  seq_state_e       state;
  logic [IDX_W-1:0] term_idx;
  logic             accept, finish;

  atan_seq_ctrl #(.NTERMS(NTERMS), .IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .out_ready(out_ready),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .accept   (accept),
    .finish   (finish),
    .state    (state),
    .term_idx (term_idx)
  );

  atan_datapath #(.W(W), .FRAC(FRAC), .NTERMS(NTERMS), .IDX_W(IDX_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .finish  (finish),
    .state   (state),
    .term_idx(term_idx),
    .in_arg  (in_arg),
    .result  (out_angle)
  );

endmodule

// File: rtl/series_atan_chk.sv
module series_atan_chk #(
  parameter int unsigned W      = 32,
  parameter int unsigned NTERMS = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_angle
);

  localparam int unsigned LAT = 1 + 2 * (NTERMS - 1);

  logic [15:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          busy_cnt <= '0;
    else if (out_valid)  busy_cnt <= '0;
    else if (!in_ready)  busy_cnt <= busy_cnt + 16'd1;
  end

  p_busy_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (busy_cnt == 16'(LAT)));

  p_no_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= 16'(LAT));

  p_hold_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_angle)));

  p_angle_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(out_valid) |-> $stable(out_angle));

endmodule

bind series_atan series_atan_chk #(.W(W), .NTERMS(NTERMS)) u_series_atan_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_angle(out_angle)
);

// File: tb/test_series_atan.sv
module test_series_atan;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 7;
  localparam int NVEC       = 12;

  localparam logic [31:0] VEC_ARG [NVEC] = '{
    32'h00000000, 32'h40000000, 32'hC0000000, 32'h20000000,
    32'hE0000000, 32'h10000000, 32'h30000000, 32'hECCCCCCD,
    32'h00000001, 32'hFFFFFFFF, 32'h39999999, 32'h0ABCDEF0
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_arg = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_angle;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  series_atan i_series_atan (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_arg   (in_arg),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_angle(out_angle)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic longint rnd(input longint a, input longint b);
    longint p;
    p = a * b;
    p = (p + (64'sd1 <<< 29)) >>> 30;
    return longint'(int'(p));
  endfunction

  // Model of R6 with the clamp of R8.
  function automatic logic [31:0] model(input logic [31:0] arg);
    longint x, x2, p, acc, t;
    longint c [4];
    x = longint'($signed(arg));
    if (x > 64'sd1073741824)  x = 64'sd1073741824;
    if (x < -64'sd1073741824) x = -64'sd1073741824;
    for (int k = 1; k < 4; k++) c[k] = (64'sd1073741824 + (2 * k + 1) / 2) / (2 * k + 1);
    x2 = rnd(x, x);
    p = x;
    acc = x;
    for (int k = 1; k < 4; k++) begin
      p = rnd(p, x2);
      t = rnd(p, c[k]);
      acc = (k % 2 == 1) ? acc - t : acc + t;
      acc = longint'(int'(acc));
    end
    return 32'(acc);
  endfunction

  // Sends one argument and waits for the result.
  task automatic run_one(input logic [31:0] a, output logic [31:0] res, output int lat);
    @(negedge clk);
    chk("R2 ready before send", 32'(in_ready), 32'd1);
    in_valid = 1'b1;
    in_arg   = a;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 busy after take", 32'(in_ready), 32'd0);
    lat = 0;
    while (!out_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    res = out_angle;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL R4 watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] res, exp, first;
    int lat;
    real xr, ref_v, got_v, bound;

    repeat (3) @(negedge clk);
    chk("R1 ready in reset", 32'(in_ready), 32'd1);
    chk("R1 valid in reset", 32'(out_valid), 32'd0);
    chk("R1 angle in reset", out_angle, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 32'(in_ready), 32'd1);
    chk("R1 angle after reset", out_angle, 32'd0);

    // Vector table: R6 exact model, R7 accuracy, R4 latency.
    for (int i = 0; i < NVEC; i++) begin
      run_one(VEC_ARG[i], res, lat);
      chk("R4 latency", 32'(lat), 32'(LAT));
      chk("R6 exact series", res, model(VEC_ARG[i]));
      xr    = $itor($signed(VEC_ARG[i])) / 1073741824.0;
      ref_v = $atan(xr);
      got_v = $itor($signed(res)) / 1073741824.0;
      bound = ((xr < 0.0 ? -xr : xr) ** 9) / 9.0 + 16.0 / 1073741824.0;
      n_checks++;
      if ((got_v - ref_v > bound) || (ref_v - got_v > bound)) begin
        n_fail++;
        $display("FAIL R7 accuracy: got %f expected %f", got_v, ref_v);
      end
      chk("R5 idle after handover", 32'(in_ready), 32'd1);
    end

    // R10: zero in gives zero out.
    run_one(32'h00000000, res, lat);
    chk("R10 zero", res, 32'h00000000);

    // R8: clamp both directions.
    run_one(32'h7FFFFFFF, res, lat);
    chk("R8 clamp high", res, model(32'h40000000));
    run_one(32'h80000000, res, lat);
    chk("R8 clamp low", res, model(32'hC0000000));
    run_one(32'h50000000, res, lat);
    chk("R8 clamp just above", res, model(32'h40000000));

    // R9: result holds while idle.
    first = res;
    repeat (5) @(negedge clk);
    chk("R9 hold idle", out_angle, first);

    // R3 and R9: traffic while busy is ignored; angle holds until finish.
    @(negedge clk);
    in_valid = 1'b1;
    in_arg   = 32'h20000000;
    @(negedge clk);
    in_arg   = 32'hD0000000;
    chk("R9 hold during work", out_angle, first);
    repeat (3) @(negedge clk);
    in_arg = 32'h3FFFFFFF;
    chk("R9 hold mid work", out_angle, first);
    while (!out_valid) @(negedge clk);
    in_valid = 1'b0;
    chk("R3 busy input ignored", out_angle, model(32'h20000000));

    // R5: consumer stalls.
    exp = out_angle;
    repeat (5) begin
      @(negedge clk);
      chk("R5 valid held", 32'(out_valid), 32'd1);
      chk("R5 angle held", out_angle, exp);
      chk("R5 no take", 32'(in_ready), 32'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R5 released", 32'(out_valid), 32'd0);
    chk("R5 ready again", 32'(in_ready), 32'd1);

    // R2: back-to-back send after handover.
    run_one(32'hF0000000, res, lat);
    chk("R2 second send", res, model(32'hF0000000));

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule